// File: doc/BRIEF.md
# Four-Operation Byte ALU with Status Flags

This block is an 8-bit arithmetic-logic unit for a simple datapath. It takes two operand bytes and a 2-bit operation code. It returns the two's-complement sum or difference of the operands, or their bitwise NAND or NOR. It also reports four status flags: carry-out, signed overflow, zero and negative.

The unit is built from separate pieces wired together in a top level. A single adder serves both arithmetic operations, and it subtracts by inverting the second operand and forcing a carry-in of one. A per-bit logic unit produces NAND or NOR. A byte-wide two-way multiplexer selects between the arithmetic path and the logic path.

The low bit of the operation code selects add or subtract in the adder, and NAND or NOR in the logic unit. The high bit steers the multiplexer. By default the result and the flags are captured in an output register with a synchronous active-low reset. A parameter can remove the register and leave a purely combinational path.

Top module: `alu_core8`

## Requirements
- R1: Operation code 00 gives (A + B) mod 256 as the result, and carry is the ninth bit of the true sum.
- R2: Operation code 01 gives (A - B) mod 256 as the result, and carry is 1 exactly when A >= B as unsigned numbers (no borrow).
- R3: Operation code 10 gives the bitwise NAND of A and B.
- R4: Operation code 11 gives the bitwise NOR of A and B.
- R5: For codes 00 and 01, overflow is 1 exactly when the signed (two's-complement) value of the true sum or difference lies outside -128..127.
- R6: For codes 10 and 11, carry and overflow are both 0.
- R7: Zero is 1 exactly when all 8 result bits are 0, for every operation code.
- R8: Negative equals result bit 7, for every operation code.
- R9: With the default registered output, result and flags reflect the inputs present at the previous rising clock edge, and stay unchanged while the inputs change between edges.
- R10: When rst_n is low at a rising clock edge, result and all four flags become 0 whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| a | input | 8 | First operand |
| b | input | 8 | Second operand (subtrahend for code 01) |
| op | input | 2 | Operation code: 00 add, 01 subtract, 10 NAND, 11 NOR |
| result | output | 8 | Operation result |
| carry | output | 1 | Adder carry-out; means "no borrow" when subtracting |
| overflow | output | 1 | Signed overflow of the arithmetic operations |
| zero | output | 1 | Result is all zeros |
| negative | output | 1 | Copy of result bit 7 |

## Verification
An arithmetic carry or overflow can occur in the same cycle as a zero result. For example, 0xFF+0x01 wraps to zero with carry set, and 0x80+0x80 wraps to zero with carry and overflow both set. Equal operands under subtraction give zero together with "no borrow". The bench drives these cases as directed vectors, and it also mixes them with seeded random operand pairs. Each vector is judged flag by flag against a reference. The reference uses signed and unsigned integer arithmetic and does not use a model of the adder. This separates a zero flag that is derived wrongly from the carry from a zero flag that is derived from the result.

// File: rtl/alu_pkg.sv
// Package: shared encodings for the byte ALU.
// Assumes: the operation code is two bits wide; bit 0 selects add/sub or
// NAND/NOR, bit 1 selects arithmetic (0) or logic (1).
package alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_NAND = 2'b10,
        OP_NOR  = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic neg;
    } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
// Module: shared adder/subtractor.
// Subtracts by inverting b and injecting carry-in = 1. Overflow compares the
// signs of the two adder inputs with the sign of the sum.
// Assumes: purely combinational, WIDTH >= 2.
module alu_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    // Conditionally invert the second operand and add with carry-in.
    always_comb begin
        b_eff = b ^ {WIDTH{sub}};
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum   = wide[MSB:0];
        cout  = wide[WIDTH];
        ovf   = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_logic.sv
// Module: bitwise logic unit producing NAND or NOR of the operands.
// Assumes: sel_nor = 0 gives NAND, 1 gives NOR; purely combinational.
module alu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sel_nor,
    output logic [WIDTH-1:0] y
);
    // One identical gate pair per bit lane.
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        assign y[i] = sel_nor ? ~(a[i] | b[i]) : ~(a[i] & b[i]);
    end
endmodule

// File: rtl/alu_mux2.sv
// Module: word-wide two-way multiplexer.
// Assumes: sel = 0 passes d0, sel = 1 passes d1.
module alu_mux2 #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] d0,
    input  logic [WIDTH-1:0] d1,
    input  logic             sel,
    output logic [WIDTH-1:0] y
);
    // Select one of the two words.
    assign y = sel ? d1 : d0;
endmodule

// File: rtl/alu_core8.sv
// Module: top level of the four-operation ALU.
// Wires the adder/subtractor, the logic unit and the result multiplexer, and
// derives the status flags. With REGISTERED = 1 the result and the flags are
// held in a register that has a synchronous active-low reset.
// Assumes: op[0] drives add/sub and NAND/NOR, op[1] drives the multiplexer.
module alu_core8 #(
    parameter int WIDTH      = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       op,
    output logic [WIDTH-1:0] result,
    output logic             carry,
    output logic             overflow,
    output logic             zero,
    output logic             negative
);
    import alu_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] arith_y;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] res_d;
    logic             add_cout;
    logic             add_ovf;
    alu_flags_t       flags_d;

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a    (a),
        .b    (b),
        .sub  (op[0]),
        .sum  (arith_y),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a       (a),
        .b       (b),
        .sel_nor (op[0]),
        .y       (logic_y)
    );

    alu_mux2 #(.WIDTH(WIDTH)) u_mux (
        .d0  (arith_y),
        .d1  (logic_y),
        .sel (op[1]),
        .y   (res_d)
    );

    // Derive status flags; arithmetic flags are masked for logic ops.
    always_comb begin
        flags_d.carry = add_cout & ~op[1];
        flags_d.ovf   = add_ovf & ~op[1];
        flags_d.zero  = ~|res_d;
        flags_d.neg   = res_d[MSB];
    end

    if (REGISTERED) begin : g_reg
        logic [WIDTH-1:0] res_q;
        alu_flags_t       flags_q;

        // Capture result and flags; synchronous active-low clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q   <= '0;
                flags_q <= '0;
            end else begin
                res_q   <= res_d;
                flags_q <= flags_d;
            end
        end

        assign result   = res_q;
        assign carry    = flags_q.carry;
        assign overflow = flags_q.ovf;
        assign zero     = flags_q.zero;
        assign negative = flags_q.neg;

        // R10: a reset edge leaves every output at zero.
        a_r10_reset_clear: assert property (@(posedge clk)
            !$past(rst_n) |-> (result == '0) && !carry && !overflow && !zero && !negative);

        // R6: logic operations never report carry or overflow.
        a_r6_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(op[1]) |-> !carry && !overflow);

        // R1: adding zero returns the first operand without carry.
        a_r1_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && ($past(op) == OP_ADD) && ($past(b) == '0)
            |-> (result == $past(a)) && !carry && !overflow);

        // R2: subtracting an equal operand gives zero with no borrow.
        a_r2_sub_self: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && ($past(op) == OP_SUB) && ($past(a) == $past(b))
            |-> zero && carry && !overflow);

        // R5: operands of opposite sign cannot overflow when added.
        a_r5_add_mixed_sign: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && ($past(op) == OP_ADD) && ($past(a[MSB]) != $past(b[MSB]))
            |-> !overflow);
    end else begin : g_comb
        assign result   = res_d;
        assign carry    = flags_d.carry;
        assign overflow = flags_d.ovf;
        assign zero     = flags_d.zero;
        assign negative = flags_d.neg;
    end
endmodule

// File: tb/sim_alu_core8.sv
// Bench: seeded random and directed vectors against a reference computed from
// integer arithmetic. Inputs change at falling edges; outputs are sampled at
// the next falling edge, after the capturing rising edge.
module sim_alu_core8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a = '0, b = '0;
    logic [1:0] op = '0;
    logic [7:0] result;
    logic       carry, overflow, zero, negative;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    alu_core8 u0 (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op),
        .result(result), .carry(carry), .overflow(overflow),
        .zero(zero), .negative(negative)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Reference: {carry, ovf, zero, neg, result}.
    function automatic logic [11:0] ref_model(input logic [7:0] x, input logic [7:0] y, input logic [1:0] o);
        int ux = int'(x), uy = int'(y);
        int sx = (ux >= 128) ? ux - 256 : ux;
        int sy = (uy >= 128) ? uy - 256 : uy;
        int t, st;
        logic [7:0] r;
        logic c, v;
        c = 1'b0; v = 1'b0;
        case (o)
            2'b00: begin t = ux + uy; st = sx + sy; r = t[7:0]; c = (t > 255); v = (st > 127) || (st < -128); end
            2'b01: begin t = ux - uy; st = sx - sy; r = t[7:0]; c = (ux >= uy); v = (st > 127) || (st < -128); end
            2'b10: r = ~(x & y);
            default: r = ~(x | y);
        endcase
        return {c, v, (r == 8'h00), r[7], r};
    endfunction

    task automatic run(input logic [7:0] ta, input logic [7:0] tb, input logic [1:0] to);
        logic [11:0] prev, e;
        string rt;
        @(negedge clk);
        prev = {carry, overflow, zero, negative, result};
        a = ta; b = tb; op = to;
        #1 chk("R9 hold", {carry, overflow, zero, negative, result}, prev);
        e = ref_model(ta, tb, to);
        @(negedge clk);
        case (to)
            2'b00: rt = "R1 add";
            2'b01: rt = "R2 sub";
            2'b10: rt = "R3 nand";
            default: rt = "R4 nor";
        endcase
        chk(rt, {4'h0, result}, {4'h0, e[7:0]});
        chk(to[1] ? "R6 carry" : (to[0] ? "R2 carry" : "R1 carry"), {11'h0, carry}, {11'h0, e[11]});
        chk(to[1] ? "R6 ovf" : "R5 ovf", {11'h0, overflow}, {11'h0, e[10]});
        chk("R7 zero", {11'h0, zero}, {11'h0, e[9]});
        chk("R8 neg", {11'h0, negative}, {11'h0, e[8]});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A1C));
        // R10: reset held with busy inputs clears everything.
        a = 8'hFF; b = 8'h01; op = 2'b00;
        repeat (3) @(negedge clk);
        chk("R10 reset", {carry, overflow, zero, negative, result}, 12'h000);
        rst_n = 1'b1;
        // Directed corners.
        run(8'h7F, 8'h01, 2'b00);
        run(8'h80, 8'h01, 2'b01);
        run(8'h00, 8'h01, 2'b01);
        run(8'hFF, 8'hFF, 2'b00);
        run(8'hFF, 8'h01, 2'b00);
        run(8'h80, 8'h80, 2'b00);
        run(8'h55, 8'h55, 2'b01);
        run(8'hFF, 8'hFF, 2'b10);
        run(8'h00, 8'h00, 2'b11);
        run(8'hFF, 8'hFF, 2'b11);
        run(8'h00, 8'h00, 2'b10);
        run(8'h7F, 8'h80, 2'b01);
        // Seeded random mix.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            run(rv[7:0], rv[15:8], rv[17:16]);
        end
        // R10: mid-run reset overrides an active operation.
        @(negedge clk);
        a = 8'h80; b = 8'h80; op = 2'b00; rst_n = 1'b0;
        @(negedge clk);
        chk("R10 midrun", {carry, overflow, zero, negative, result}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {carry, overflow, zero, negative, result}, ref_model(8'h80, 8'h80, 2'b00));
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule